// File: doc/BRIEF.md
# Serial Character Transmitter with Inter-Character Gap and Address Marking

This block turns parallel characters into an asynchronous-style serial frame on a single output line. A producer writes a character into a one-deep holding register. As soon as the shifter is free, the character moves into it. The frame then goes out one bit per bit period: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. An external single-cycle bit-rate enable paces the bits. The line changes only on a clock edge where that enable is high.

Three configuration inputs choose the character length, the parity treatment and the stop-bit count. They are sampled when a character enters the shifter. A gap input can force the line to stay high for a whole number of bit periods after every character. When the parity selection is 11x, the block runs in address-marking mode. A one-cycle address command makes the next accepted character carry a parity bit of 1, and every other character carries 0. Two status outputs tell the producer whether the holding register can take a character and whether the whole transmit path is quiet.

Top module: `uart_tx_guard`

## Requirements
- R1: A frame is one low start bit, the data bits least significant bit first, the parity bit when enabled, and then the stop bits, each lasting one bit period. `txd` is high whenever no frame or gap is in progress.
- R2: `cfg_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused high bits of `wr_data` are not sent.
- R3: `cfg_par` sets the parity bit. 000 makes the count of ones in data plus parity even. 001 makes it odd. 010 sends 0 and 011 sends 1. 100 and 101 send no parity bit.
- R4: `cfg_stop` = 0 sends one stop bit and `cfg_stop` = 1 sends two.
- R5: `txd` changes only on a clock edge where `baud_en` is high.
- R6: `tx_rdy` is high while the holding register is empty. It drops in the cycle after an accepted write. It rises again when the character moves into the shifter, and the shifter is then busy.
- R7: `tx_empty` is high only when the holding register is empty and no frame or gap is in progress. It is low during the gap.
- R8: A write while `tx_rdy` is low is ignored. The queued character is sent unchanged and no extra frame appears.
- R9: With `guard_len` = G, the line stays high for exactly G bit periods after each frame's stop bits before the next start bit. With G = 0 and a character waiting, the next start bit follows the last stop bit at once.
- R10: With `cfg_par` = 11x, a `send_addr` pulse makes the next accepted character (including a write in the same cycle) go out with parity bit 1. Every other character goes out with parity bit 0.
- R11: After reset, `txd`, `tx_rdy` and `tx_empty` are high and no address request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_en | input | 1 | One-cycle pulse marking each bit-period boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Character to send |
| send_addr | input | 1 | Command: mark the next written character as an address |
| cfg_len | input | 2 | Data length select |
| cfg_par | input | 3 | Parity mode select |
| cfg_stop | input | 1 | Stop-bit count select |
| guard_len | input | GW | Idle bit periods inserted after each frame |
| txd | output | 1 | Serial data line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The bound checker watches four rules on every cycle:
- the line moves only on enabled edges;
- an accepted write always drops the ready flag;
- a rising ready flag always means the shifter has just become busy;
- a quiet path implies both a ready flag and a high line.

The frame contents cannot be seen cycle by cycle; only the bench's directed scenarios reconstruct whole frames. The same holds for bit order, length, parity value, stop count and the exact start-to-start spacing with and without a gap. Likewise, only the bench can confirm that a refused write leaves the queued character intact and that address marking covers exactly one character.

// File: rtl/uart_tx_guard.sv
module uart_tx_guard #(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          send_addr,
  input  logic [1:0]    cfg_len,
  input  logic [2:0]    cfg_par,
  input  logic          cfg_stop,
  input  logic [GW-1:0] guard_len,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_empty
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GUARD} st_t;

  st_t           st;
  logic [DW-1:0] hold_q;
  logic          hold_full, hold_addr, addr_pend;
  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          txd_q;

  logic [FW-1:0] frame;
  logic [CW-1:0] flen;
  logic          has_par, pbit, dpar;
  int            nbits;

  always_comb begin
    nbits = DW - 3 + int'(cfg_len);
    frame = '1;
    frame[0] = 1'b0;
    dpar = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nbits) begin
        frame[i+1] = hold_q[i];
        dpar = dpar ^ hold_q[i];
      end
    end
    case (cfg_par)
      3'b000:         pbit = dpar;
      3'b001:         pbit = ~dpar;
      3'b010:         pbit = 1'b0;
      3'b011:         pbit = 1'b1;
      3'b110, 3'b111: pbit = hold_addr;
      default:        pbit = 1'b0;
    endcase
    has_par = (cfg_par[2:1] != 2'b10);
    if (has_par) frame[nbits+1] = pbit;
    flen = CW'(2 + nbits + int'(has_par) + int'(cfg_stop));
  end

  wire wr_ok = wr_en & ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_q    <= '0;
      hold_full <= 1'b0;
      hold_addr <= 1'b0;
      addr_pend <= 1'b0;
      sh        <= '1;
      cnt       <= '0;
      gcnt      <= '0;
      txd_q     <= 1'b1;
    end else begin
      if (wr_ok) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        hold_addr <= addr_pend | send_addr;
        addr_pend <= 1'b0;
      end else if (send_addr) begin
        addr_pend <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          if (hold_full) begin
            sh        <= frame;
            cnt       <= flen;
            st        <= S_SHIFT;
            hold_full <= 1'b0;
          end
        end
        S_SHIFT: begin
          if (baud_en) begin
            if (cnt != '0) begin
              txd_q <= sh[0];
              sh    <= {1'b1, sh[FW-1:1]};
              cnt   <= cnt - 1'b1;
            end else if (guard_len != '0) begin
              st    <= S_GUARD;
              gcnt  <= guard_len;
              txd_q <= 1'b1;
            end else if (hold_full) begin
              txd_q     <= frame[0];
              sh        <= {1'b1, frame[FW-1:1]};
              cnt       <= flen - 1'b1;
              hold_full <= 1'b0;
            end else begin
              st    <= S_IDLE;
              txd_q <= 1'b1;
            end
          end
        end
        default: begin
          if (baud_en) begin
            if (gcnt > 1) begin
              gcnt <= gcnt - 1'b1;
            end else if (hold_full) begin
              st        <= S_SHIFT;
              txd_q     <= frame[0];
              sh        <= {1'b1, frame[FW-1:1]};
              cnt       <= flen - 1'b1;
              hold_full <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign txd      = txd_q;
  assign tx_rdy   = ~hold_full;
  assign tx_empty = ~hold_full & (st == S_IDLE);
endmodule

// File: rtl/uart_tx_guard_chk.sv
module uart_tx_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_en,
  input logic wr_en,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty
);
  assert_txd_on_baud_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> $past(baud_en));

  assert_wr_drops_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_rdy) |=> !tx_rdy);

  assert_rdy_rise_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> !tx_empty);

  assert_empty_needs_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_rdy);

  assert_empty_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
endmodule

bind uart_tx_guard uart_tx_guard_chk chk (
  .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .wr_en(wr_en),
  .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
);

// File: tb/tb_uart_tx_guard.sv
module tb_uart_tx_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, send_addr = 1'b0, cfg_stop = 1'b0;
  logic [7:0] wr_data = '0, guard_len = '0;
  logic [1:0] cfg_len = 2'b11;
  logic [2:0] cfg_par = 3'b100;
  logic txd, tx_rdy, tx_empty, baud_en;
  int bcnt = 0, total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) bcnt <= (!rst_n || bcnt == DIV-1) ? 0 : bcnt + 1;
  assign baud_en = rst_n && (bcnt == DIV-1);

  uart_tx_guard dut (.clk(clk), .rst_n(rst_n), .baud_en(baud_en), .wr_en(wr_en),
    .wr_data(wr_data), .send_addr(send_addr), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .guard_len(guard_len), .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] d, input logic [1:0] len, input logic [2:0] par,
                                input logic stp, input logic abit, output logic [11:0] v, output int nb);
    int n = 5 + int'(len);
    logic ones = 1'b0;
    v = '1; nb = 0;
    v[nb++] = 1'b0;
    for (int i = 0; i < n; i++) begin v[nb++] = d[i]; ones ^= d[i]; end
    if (par == 3'b000) v[nb++] = ones;
    else if (par == 3'b001) v[nb++] = ~ones;
    else if (par == 3'b010) v[nb++] = 1'b0;
    else if (par == 3'b011) v[nb++] = 1'b1;
    else if (par[2:1] == 2'b11) v[nb++] = abit;
    v[nb++] = 1'b1;
    if (stp) v[nb++] = 1'b1;
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk) wr_en = 1'b1; wr_data = d;
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rx(input int nb, output logic [11:0] got);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i < nb-1) repeat (DIV) @(negedge clk);
    end
  endtask

  task automatic start_gap(input int nb, output int gap);
    while (txd !== 1'b0) @(negedge clk);
    repeat (nb*DIV-1) @(negedge clk);
    gap = nb*DIV-1;
    while (txd !== 1'b0) begin @(negedge clk); gap++; end
  endtask

  task automatic t_reset;
    check("R11 txd", txd, 1);
    check("R11 tx_rdy", tx_rdy, 1);
    check("R11 tx_empty", tx_empty, 1);
  endtask

  task automatic t_frame(input string tag, input logic [7:0] d, input logic [1:0] len,
                         input logic [2:0] par, input logic stp);
    logic [11:0] exp, got;
    int nb;
    @(negedge clk) cfg_len = len; cfg_par = par; cfg_stop = stp; guard_len = 0;
    model(d, len, par, stp, 1'b0, exp, nb);
    fork
      rx(nb, got);
      wr(d);
    join
    check(tag, got & ((12'd1 << nb) - 1), exp & ((12'd1 << nb) - 1));
    repeat (8) @(negedge clk);
    check("R7 idle after frame", {txd, tx_empty}, 2'b11);
  endtask

  task automatic t_status;
    logic [11:0] exp, g1, g2;
    int nb;
    @(negedge clk) cfg_len = 2'b11; cfg_par = 3'b100; cfg_stop = 0; guard_len = 0;
    model(8'h3A, 2'b11, 3'b100, 1'b0, 1'b0, exp, nb);
    fork
      begin rx(nb, g1); rx(nb, g2); end
      begin
        wr(8'hC3);
        check("R6 rdy low after write", tx_rdy, 0);
        repeat (2) @(negedge clk);
        check("R6 rdy back, shifter busy", {tx_rdy, tx_empty}, 2'b10);
        wr(8'h3A);
        wr(8'hEE);
        check("R8 rdy still low", tx_rdy, 0);
      end
    join
    model(8'hC3, 2'b11, 3'b100, 1'b0, 1'b0, exp, nb);
    check("R1 first char", g1[9:0], exp[9:0]);
    model(8'h3A, 2'b11, 3'b100, 1'b0, 1'b0, exp, nb);
    check("R8 queued char unchanged", g2[9:0], exp[9:0]);
    begin
      int lows = 0;
      repeat (60) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R8 no extra frame", lows, 0);
      check("R7 empty at end", tx_empty, 1);
    end
  endtask

  task automatic t_gap(input logic [7:0] g, input int expgap);
    int gap;
    @(negedge clk) cfg_len = 2'b11; cfg_par = 3'b100; cfg_stop = 0; guard_len = g;
    fork
      start_gap(10, gap);
      begin
        wr(8'h55);
        while (tx_rdy !== 1'b1) @(negedge clk);
        wr(8'h0F);
      end
    join
    check($sformatf("R9 start spacing guard=%0d", g), gap, expgap);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  task automatic t_gap_empty;
    logic [11:0] got;
    @(negedge clk) cfg_len = 2'b11; cfg_par = 3'b100; cfg_stop = 0; guard_len = 8'd3;
    fork
      rx(10, got);
      wr(8'h81);
    join
    repeat (6) @(negedge clk);
    check("R7 not empty during gap", {txd, tx_rdy, tx_empty}, 3'b110);
    repeat (12) @(negedge clk);
    check("R7 empty after gap", tx_empty, 1);
  endtask

  task automatic t_mdrop;
    logic [11:0] g0, g1, g2, exp;
    int nb;
    @(negedge clk) cfg_len = 2'b11; cfg_par = 3'b110; cfg_stop = 0; guard_len = 0;
    fork
      begin rx(11, g0); rx(11, g1); rx(11, g2); end
      begin
        wr(8'h01);
        while (tx_rdy !== 1'b1) @(negedge clk);
        @(negedge clk) send_addr = 1'b1;
        @(negedge clk) send_addr = 1'b0;
        wr(8'h3C);
        while (tx_rdy !== 1'b1) @(negedge clk);
        wr(8'h3C);
      end
    join
    model(8'h01, 2'b11, 3'b110, 1'b0, 1'b0, exp, nb);
    check("R10 data parity 0", g0[10:0], exp[10:0]);
    model(8'h3C, 2'b11, 3'b110, 1'b0, 1'b1, exp, nb);
    check("R10 address parity 1", g1[10:0], exp[10:0]);
    model(8'h3C, 2'b11, 3'b110, 1'b0, 1'b0, exp, nb);
    check("R10 following parity 0", g2[10:0], exp[10:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_frame("R1 R2 8 data no parity", 8'hA5, 2'b11, 3'b100, 1'b0);
    t_frame("R3 R4 7 data even 2 stop", 8'h53, 2'b10, 3'b000, 1'b1);
    t_frame("R2 R3 5 data odd", 8'hF6, 2'b00, 3'b001, 1'b0);
    t_frame("R3 6 data force1 2 stop", 8'h2B, 2'b01, 3'b011, 1'b1);
    t_frame("R3 8 data force0", 8'hFF, 2'b11, 3'b010, 1'b0);
    t_status;
    t_gap(8'd0, 10*DIV);
    t_gap(8'd3, 13*DIV);
    t_gap_empty;
    t_mdrop;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule